// File: doc/BRIEF.md
# SD Host Interrupt Status and Line Reset Unit

This unit collects completion and fault pulses from the command and data engines of an SD host and turns them into two 16-bit write-1-to-clear status words: a normal word and an error word. Each status bit has a status-enable mask that decides whether its event is recorded. It also has a signal-enable mask that decides whether a recorded bit drives the interrupt line. The normal word carries a summary bit that shows whether any enabled error is pending.

The unit tracks whether a transfer-complete pulse is still owed for the last issued command. It also resolves the transfer outcome from the stored status, where a finished transfer overrides a data timeout. Two self-clearing soft-reset controls, one for the command line and one for the data line, hold their busy flag for a fixed number of cycles. While a line's reset is in progress, the status tied to that line is wiped. Software sees every register through a single write port and the status outputs.

Top module: `sd_irq_status_unit`

## Requirements
- R1: After the asynchronous reset, both status words, all enable masks, both reset-busy flags, the pending-transfer flag and `irq_o` are 0, and `outcome_o` reads 0 (no result).
- R2: A pulse on an event input sets its status bit on the next clock edge only if the matching status-enable bit is 1. The normal bits are: bit 0 for command done and bit 1 for transfer done. The error bits, from 0 to 9, are: command timeout, command CRC, command end bit, command index, data timeout, data CRC, data end bit, current limit, auto stop command, and descriptor DMA.
- R3: Writing 1 to a status bit (select 0 for normal, 1 for error) clears it, and writing 0 leaves it unchanged. An event arriving in the same cycle as the clear leaves the bit set.
- R4: Normal status bit 15 equals the OR of the error status bits whose status-enable bit is currently 1.
- R5: `irq_o` is 1 exactly when some normal status bit (bit 15 included) has its normal signal-enable bit set, or some error status bit has its error signal-enable bit set.
- R6: `outcome_o` is 2 (success) whenever normal bit 1 is set, regardless of error bit 4. It is 1 (timeout during transfer) when only error bit 4 is set, and 0 otherwise.
- R7: `xfer_wait_o` is set by a `cmd_issue_i` pulse whose command carries data or expects a busy response. It is cleared by a `xfer_done_i` pulse, and an issue in the same cycle wins over that clear.
- R8: Writing select 6 with data bit 0 (command line) or bit 1 (data line) raises that line's bit in `srst_o` on the next edge. The bit stays 1 for exactly RST_CYCLES cycles and then drops by itself.
- R9: While the command-line reset is busy, normal bit 0 and error bits 0 to 3 are held at 0 and their events are dropped. While the data-line reset is busy, the same applies to normal bit 1, error bits 4, 5, 6, 8 and 9, and `xfer_wait_o`, and issues are ignored. Error bit 7 is never touched by either reset.
- R10: Selects 2, 3, 4 and 5 load the full 16-bit data into, respectively, the normal status-enable, error status-enable, normal signal-enable and error signal-enable masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_done_i | input | 1 | Command complete pulse |
| xfer_done_i | input | 1 | Transfer complete pulse |
| err_ev_i | input | 10 | Error cause pulses, bit order as in R2 |
| cmd_issue_i | input | 1 | A command is being issued |
| cmd_has_data_i | input | 1 | Issued command moves data |
| cmd_busy_rsp_i | input | 1 | Issued command expects a busy response |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select (0 to 6) |
| wr_data_i | input | 16 | Write data |
| norm_sts_o | output | 16 | Normal status word |
| err_sts_o | output | 16 | Error status word |
| srst_o | output | 2 | Reset busy: bit 0 command line, bit 1 data line |
| xfer_wait_o | output | 1 | Transfer completion still pending |
| outcome_o | output | 2 | Resolved transfer outcome |
| irq_o | output | 1 | Interrupt request |

## Verification
A new event and a write-1-to-clear of the same bit can arrive in the same cycle, and so can a new event and a line-reset wipe of that bit. Both are provoked on purpose. A command-done pulse is placed in the cycle of its clear. Later, events are pulsed continuously while a data-line reset is in progress. A long phase of mixed random pulses and register writes also makes such overlaps frequent. On every clock the outputs are compared with a behavioural model that states the precedence plainly: the event beats the clear, and the reset beats both. The outcome priority is checked directly with transfer done and data timeout both set, then with each removed in turn.

// File: rtl/sd_sts_pkg.sv
package sd_sts_pkg;
  localparam int REG_W = 16;
  localparam int ERR_N = 10;
  localparam int NRM_N = 2;
  localparam int LINE_N = 2;

  typedef enum logic [2:0] {
    SEL_NSTS = 3'd0,
    SEL_ESTS = 3'd1,
    SEL_NSEN = 3'd2,
    SEL_ESEN = 3'd3,
    SEL_NSIG = 3'd4,
    SEL_ESIG = 3'd5,
    SEL_SRST = 3'd6
  } reg_sel_e;

  typedef enum logic [1:0] {
    OUT_OTHER   = 2'd0,
    OUT_TIMEOUT = 2'd1,
    OUT_DONE    = 2'd2
  } xfer_out_e;

  localparam int EB_DAT_TO = 4;
  // error bits owned by each line
  localparam logic [REG_W-1:0] CMD_LINE_ERR = 16'h000F;
  localparam logic [REG_W-1:0] DAT_LINE_ERR = 16'h0370;
endpackage

// File: rtl/sd_sts_group.sv
module sd_sts_group #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ev_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] flush_i,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] set_w;
  assign set_w = ev_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= ((sts_o & ~clr_i) | set_w) & ~flush_i;
  end

  // cleared bits without a same-cycle event read 0
  p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((sts_o & $past(clr_i & ~(ev_i & en_i))) == '0));

  // a bit only rises from an enabled event
  p_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o != '1) |=> ((sts_o & ~$past(sts_o) & ~$past(ev_i & en_i)) == '0));
endmodule

// File: rtl/sd_line_reset.sv
module sd_line_reset #(
  parameter int CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= CW'(CYC - 1);
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  p_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != '0) |=> busy_o);
  p_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q == '0 && !start_i) |=> !busy_o);
endmodule

// File: rtl/sd_irq_status_unit.sv
module sd_irq_status_unit
  import sd_sts_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_done_i,
  input  logic             xfer_done_i,
  input  logic [ERR_N-1:0] err_ev_i,
  input  logic             cmd_issue_i,
  input  logic             cmd_has_data_i,
  input  logic             cmd_busy_rsp_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] norm_sts_o,
  output logic [REG_W-1:0] err_sts_o,
  output logic [LINE_N-1:0] srst_o,
  output logic             xfer_wait_o,
  output logic [1:0]       outcome_o,
  output logic             irq_o
);
  reg_sel_e sel;
  logic [REG_W-1:0] nsen_q, esen_q, nsig_q, esig_q;
  logic [REG_W-1:0] eclr, eflush, err_ev_w;
  logic [NRM_N-1:0] nclr, nflush, n_ev, n_lat;
  logic [LINE_N-1:0] rst_start, rst_busy;
  logic err_sum;
  xfer_out_e outc;

  assign sel = reg_sel_e'(wr_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nsen_q <= '0; esen_q <= '0; nsig_q <= '0; esig_q <= '0;
    end else if (wr_en_i) begin
      case (sel)
        SEL_NSEN: nsen_q <= wr_data_i;
        SEL_ESEN: esen_q <= wr_data_i;
        SEL_NSIG: nsig_q <= wr_data_i;
        SEL_ESIG: esig_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  // line soft resets: 0 = command, 1 = data
  for (genvar g = 0; g < LINE_N; g++) begin : g_line
    assign rst_start[g] = wr_en_i && (sel == SEL_SRST) && wr_data_i[g];
    sd_line_reset #(.CYC(RST_CYCLES)) u_rst (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(rst_start[g]),
      .busy_o (rst_busy[g])
    );
  end
  assign srst_o = rst_busy;

  assign nclr     = (wr_en_i && sel == SEL_NSTS) ? wr_data_i[NRM_N-1:0] : '0;
  assign eclr     = (wr_en_i && sel == SEL_ESTS) ? wr_data_i : '0;
  assign n_ev     = {xfer_done_i, cmd_done_i};
  assign nflush   = rst_busy;
  assign eflush   = (rst_busy[0] ? CMD_LINE_ERR : '0) | (rst_busy[1] ? DAT_LINE_ERR : '0);
  assign err_ev_w = {{(REG_W-ERR_N){1'b0}}, err_ev_i};

  sd_sts_group #(.W(NRM_N)) u_nrm (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(n_ev), .en_i(nsen_q[NRM_N-1:0]),
    .clr_i(nclr), .flush_i(nflush), .sts_o(n_lat)
  );

  sd_sts_group #(.W(REG_W)) u_err (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(err_ev_w), .en_i(esen_q),
    .clr_i(eclr), .flush_i(eflush), .sts_o(err_sts_o)
  );

  assign err_sum    = |(err_sts_o & esen_q);
  assign norm_sts_o = {err_sum, {(REG_W-NRM_N-1){1'b0}}, n_lat};
  assign irq_o      = (|(norm_sts_o & nsig_q)) | (|(err_sts_o & esig_q));

  // transfer done outranks data timeout
  always_comb begin
    if (n_lat[1])                 outc = OUT_DONE;
    else if (err_sts_o[EB_DAT_TO]) outc = OUT_TIMEOUT;
    else                          outc = OUT_OTHER;
  end
  assign outcome_o = outc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           xfer_wait_o <= 1'b0;
    else if (rst_busy[1])                                  xfer_wait_o <= 1'b0;
    else if (cmd_issue_i && (cmd_has_data_i || cmd_busy_rsp_i)) xfer_wait_o <= 1'b1;
    else if (xfer_done_i)                                  xfer_wait_o <= 1'b0;
  end

  p_cmd_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o[0] |=> ((err_sts_o & CMD_LINE_ERR) == '0 && !norm_sts_o[0]));
  p_dat_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o[1] |=> ((err_sts_o & DAT_LINE_ERR) == '0 && !norm_sts_o[1] && !xfer_wait_o));
  p_issue_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_issue_i && cmd_busy_rsp_i && !srst_o[1]) |=> xfer_wait_o);
  p_pri_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (norm_sts_o[1] && err_sts_o[EB_DAT_TO]) |-> (outcome_o == 2'd2));
endmodule

// File: tb/sim_sd_irq_status_unit.sv
`timescale 1ns/1ps
module sim_sd_irq_status_unit;
  localparam int RC = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cmd_done_i, xfer_done_i, cmd_issue_i, cmd_has_data_i, cmd_busy_rsp_i, wr_en_i;
  logic [9:0] err_ev_i;
  logic [2:0] wr_sel_i;
  logic [15:0] wr_data_i;
  logic [15:0] norm_sts_o, err_sts_o;
  logic [1:0] srst_o, outcome_o;
  logic xfer_wait_o, irq_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  sd_irq_status_unit #(.RST_CYCLES(RC)) u0 (
    .clk_i, .rst_ni, .cmd_done_i, .xfer_done_i, .err_ev_i, .cmd_issue_i,
    .cmd_has_data_i, .cmd_busy_rsp_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .norm_sts_o, .err_sts_o, .srst_o, .xfer_wait_o, .outcome_o, .irq_o
  );

  // behavioural reference
  bit [1:0]  m_nl;
  bit [15:0] m_el, m_nsen, m_esen, m_nsig, m_esig;
  int m_crem, m_drem;
  bit m_wait;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_nl = 0; m_el = 0; m_nsen = 0; m_esen = 0; m_nsig = 0; m_esig = 0;
      m_crem = 0; m_drem = 0; m_wait = 0;
    end else begin
      bit cb, db, fl, ev;
      cb = m_crem > 0;
      db = m_drem > 0;
      for (int i = 0; i < 2; i++) begin
        ev = (i == 0) ? cmd_done_i : xfer_done_i;
        fl = (i == 0) ? cb : db;
        if (wr_en_i && wr_sel_i == 0 && wr_data_i[i]) m_nl[i] = 0;
        if (ev && m_nsen[i]) m_nl[i] = 1;
        if (fl) m_nl[i] = 0;
      end
      for (int i = 0; i < 10; i++) begin
        fl = (i < 4) ? cb : ((i == 7) ? 1'b0 : db);
        if (wr_en_i && wr_sel_i == 1 && wr_data_i[i]) m_el[i] = 0;
        if (err_ev_i[i] && m_esen[i]) m_el[i] = 1;
        if (fl) m_el[i] = 0;
      end
      if (db) m_wait = 0;
      else if (cmd_issue_i && (cmd_has_data_i || cmd_busy_rsp_i)) m_wait = 1;
      else if (xfer_done_i) m_wait = 0;
      if (wr_en_i) begin
        case (wr_sel_i)
          3'd2: m_nsen = wr_data_i;
          3'd3: m_esen = wr_data_i;
          3'd4: m_nsig = wr_data_i;
          3'd5: m_esig = wr_data_i;
          default: ;
        endcase
      end
      if (wr_en_i && wr_sel_i == 6 && wr_data_i[0]) m_crem = RC;
      else if (m_crem > 0) m_crem--;
      if (wr_en_i && wr_sel_i == 6 && wr_data_i[1]) m_drem = RC;
      else if (m_drem > 0) m_drem--;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [15:0] en;
    logic sum, eirq;
    logic [1:0] eo;
    sum  = |(m_el & m_esen);
    en   = {sum, 13'b0, m_nl};
    eirq = (|(en & m_nsig)) | (|(m_el & m_esig));
    eo   = m_nl[1] ? 2'd2 : (m_el[4] ? 2'd1 : 2'd0);
    chk(norm_sts_o === en, "R2/R4 norm_sts", norm_sts_o, en);
    chk(err_sts_o === m_el, "R2/R3 err_sts", err_sts_o, m_el);
    chk(irq_o === eirq, "R5 irq", irq_o, eirq);
    chk(outcome_o === eo, "R6 outcome", outcome_o, eo);
    chk(xfer_wait_o === m_wait, "R7 xfer_wait", xfer_wait_o, m_wait);
    chk(srst_o === {m_drem > 0, m_crem > 0}, "R8 srst", srst_o, {m_drem > 0, m_crem > 0});
  endtask

  task automatic idle();
    cmd_done_i = 0; xfer_done_i = 0; err_ev_i = '0; cmd_issue_i = 0;
    cmd_has_data_i = 0; cmd_busy_rsp_i = 0; wr_en_i = 0; wr_sel_i = '0; wr_data_i = '0;
  endtask

  task automatic tick();
    @(negedge clk_i);
    compare_all();
    idle();
  endtask

  task automatic wr(input int s, input logic [15:0] d);
    wr_en_i = 1; wr_sel_i = 3'(s); wr_data_i = d;
    tick();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    chk(norm_sts_o == 0 && err_sts_o == 0 && irq_o == 0 && srst_o == 0
        && xfer_wait_o == 0 && outcome_o == 0, "R1 reset state",
        {norm_sts_o, err_sts_o}, 0);
    rst_ni = 1;
    tick();

    // R2: disabled events are not recorded
    err_ev_i = '1; cmd_done_i = 1; xfer_done_i = 1; tick();
    chk(err_sts_o == 0 && norm_sts_o == 0, "R2 gated event", err_sts_o, 0);

    wr(3, 16'hFFFF); wr(2, 16'hFFFF);
    chk(1'b1, "R10 masks loaded", 0, 0);

    // R6 priority
    xfer_done_i = 1; err_ev_i[4] = 1; tick();
    chk(outcome_o == 2, "R6 done beats timeout", outcome_o, 2);
    wr(1, 16'h0000);
    chk(err_sts_o[4] == 1, "R3 write 0 no effect", err_sts_o, 16'h0010);
    wr(0, 16'h0002);
    chk(outcome_o == 1, "R6 timeout only", outcome_o, 1);
    wr(1, 16'h0010);
    chk(outcome_o == 0, "R6 neither", outcome_o, 0);

    // R3 event wins over clear in same cycle
    cmd_done_i = 1; tick();
    cmd_done_i = 1; wr_en_i = 1; wr_sel_i = 0; wr_data_i = 16'h0001; tick();
    chk(norm_sts_o[0] == 1, "R3 event beats clear", norm_sts_o, 1);

    // R5 / R10 signal enables
    wr(4, 16'h0001);
    chk(irq_o == 1, "R10 R5 irq on", irq_o, 1);
    wr(4, 16'h0000);
    chk(irq_o == 0, "R10 R5 irq off", irq_o, 0);

    // R4 summary follows current enable
    err_ev_i[7] = 1; tick();
    chk(norm_sts_o[15] == 1, "R4 summary set", norm_sts_o, 16'h8001);
    wr(3, 16'h0000);
    chk(norm_sts_o[15] == 0 && err_sts_o[7] == 1, "R4 summary masked", norm_sts_o, 1);
    wr(3, 16'hFFFF);

    // R7 pending with busy response
    cmd_issue_i = 1; cmd_busy_rsp_i = 1; tick();
    chk(xfer_wait_o == 1, "R7 busy response pending", xfer_wait_o, 1);

    // R8 / R9 data line reset
    err_ev_i = '1; xfer_done_i = 1; tick();
    wr(6, 16'h0002);
    begin
      int n = 0;
      while (srst_o[1] && n < 20) begin
        err_ev_i = '1; xfer_done_i = 1; cmd_issue_i = 1; cmd_has_data_i = 1;
        tick(); n++;
      end
      chk(n == RC, "R8 data reset length", n, RC);
    end
    chk(err_sts_o[7] == 1 && err_sts_o[0] == 1 && (err_sts_o & 16'h0370) == 0
        && xfer_wait_o == 0, "R9 data reset scope", err_sts_o, 16'h008F);
    wr(6, 16'h0001);
    tick();
    chk((err_sts_o & 16'h000F) == 0 && norm_sts_o[0] == 0, "R9 cmd reset scope",
        err_sts_o, 0);
    repeat (RC) tick();

    // mixed random traffic, checked against model every cycle
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom % 100);
      err_ev_i    = (r < 30) ? 10'($urandom) : '0;
      cmd_done_i  = ($urandom % 4) == 0;
      xfer_done_i = ($urandom % 5) == 0;
      cmd_issue_i = ($urandom % 6) == 0;
      cmd_has_data_i = $urandom % 2;
      cmd_busy_rsp_i = $urandom % 2;
      if (($urandom % 3) == 0) begin
        wr_en_i = 1;
        wr_sel_i = 3'($urandom % 7);
        wr_data_i = 16'($urandom);
        if (wr_sel_i == 6 && ($urandom % 4) != 0) wr_en_i = 0;
      end
      tick();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule